// File: doc/BRIEF.md
# 8b/10b Transmit Character Encoder

This block turns one byte per clock, together with a control flag, into a 10-bit line character that a serializer can send. It follows the standard 8b/10b code: the low five bits of the byte go through a 5b/6b step and the high three bits go through a 3b/4b step. The block keeps a running disparity from one character to the next and uses it to choose between the negative and the positive form of each code, so that over time the line carries as many ones as zeros.

A per-character override lets the caller set the starting disparity of the current character directly, which is useful for lane bring-up and test patterns. Only the twelve legal control characters are encoded as control codes. Any other byte sent with the control flag raises an error flag and goes out as the data code for that byte. Results are registered, and nothing moves on cycles where the valid strobe is low. When several lanes are needed, a wrapper places one instance per lane, and each lane gets its own bit of the force controls.

Top module: `tx_8b10b_encoder`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `code_out` is 0, `rd_out` is 0 (negative) and `ctrl_err` is 0. The first character after reset, when not forced, is encoded from the negative-disparity column.
- R2: Data characters (`in_ctrl`=0) follow the standard 8b/10b Dx.y code, with x = `in_byte[4:0]` and y = `in_byte[7:5]`. `code_out[9:4]` holds the 6-bit group abcdei with a in bit 9, and `code_out[3:0]` holds fghj with f in bit 3. Bit 9 goes on the line first.
- R3: When a character is not forced, its starting disparity is `rd_out`. After the character, `rd_out` becomes 1 if the code has six ones, becomes 0 if it has four ones, and otherwise keeps the starting value.
- R4: With `in_ctrl`=1, the bytes for K28.0–K28.7 (x=28, any y), K23.7, K27.7, K29.7 and K30.7 (y=7) produce the standard Kx.y codes and leave `ctrl_err` at 0.
- R5: With `in_ctrl`=1 and any other byte, `ctrl_err` is 1 for that character, and `code_out` and `rd_out` are exactly what the same byte would give as data.
- R6: For data D.x.7, fghj uses the alternate form (0111 in the negative column, 1000 in the positive column) when the disparity after the 6-bit group is negative and x is 17, 18 or 20, or when it is positive and x is 11, 13 or 14.
- R7: When `force_rd` is 1, the character starts from disparity `force_rd_val` (1 = positive, 0 = negative), whatever the tracked value is. `rd_out` then follows R3 from that start.
- R8: On a clock edge where `in_valid` is 0, `code_out`, `rd_out` and `ctrl_err` keep their values.
- R9: A stream of legal characters encoded without forcing never puts more than five equal bits in a row on the line.
- R10: A character presented with `in_valid`=1 appears on `code_out` after exactly one rising clock edge.
- R11: Every character has four, five or six ones. Six ones occur only from a negative start, and four ones only from a positive start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Encode the present input on this edge |
| in_byte | input | 8 | Byte to encode (x = bits 4:0, y = bits 7:5) |
| in_ctrl | input | 1 | 1 = control character, 0 = data |
| force_rd | input | 1 | Override the starting disparity of this character |
| force_rd_val | input | 1 | Forced starting disparity, 1 = positive |
| code_out | output | 10 | Encoded character, bit 9 sent first |
| rd_out | output | 1 | Running disparity after the last encoded character |
| ctrl_err | output | 1 | Last character asked for an illegal control code |

## Verification
The code widths are fixed by the line code, so the block has no parameters and the bench builds it as it stands. Because the space is small, the bench can sweep every byte, with the flag both clear and set, from both forced starting disparities. That reaches every legal control code, every illegal control request and every case of the alternate D.x.7 form. An unforced stream then checks disparity tracking and run length across many character boundaries, including a reset taken in the middle of the stream.

// File: rtl/tx8b10b_pkg.sv
package tx8b10b_pkg;

  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;

  // Negative-column abcdei group for data value x.
  function automatic logic [SIX_W-1:0] six_neg(input logic [X_W-1:0] x);
    logic [SIX_W-1:0] s;
    case (x)
      5'd0:  s = 6'b100111;
      5'd1:  s = 6'b011101;
      5'd2:  s = 6'b101101;
      5'd3:  s = 6'b110001;
      5'd4:  s = 6'b110101;
      5'd5:  s = 6'b101001;
      5'd6:  s = 6'b011001;
      5'd7:  s = 6'b111000;
      5'd8:  s = 6'b111001;
      5'd9:  s = 6'b100101;
      5'd10: s = 6'b010101;
      5'd11: s = 6'b110100;
      5'd12: s = 6'b001101;
      5'd13: s = 6'b101100;
      5'd14: s = 6'b011100;
      5'd15: s = 6'b010111;
      5'd16: s = 6'b011011;
      5'd17: s = 6'b100011;
      5'd18: s = 6'b010011;
      5'd19: s = 6'b110010;
      5'd20: s = 6'b001011;
      5'd21: s = 6'b101010;
      5'd22: s = 6'b011010;
      5'd23: s = 6'b111010;
      5'd24: s = 6'b110011;
      5'd25: s = 6'b100110;
      5'd26: s = 6'b010110;
      5'd27: s = 6'b110110;
      5'd28: s = 6'b001110;
      5'd29: s = 6'b101110;
      5'd30: s = 6'b011110;
      default: s = 6'b101011;
    endcase
    return s;
  endfunction

  // fghj for data when the disparity after the 6-bit group is negative.
  function automatic logic [FOUR_W-1:0] four_neg_data(input logic [Y_W-1:0] y);
    logic [FOUR_W-1:0] f;
    case (y)
      3'd0: f = 4'b1011;
      3'd1: f = 4'b1001;
      3'd2: f = 4'b0101;
      3'd3: f = 4'b1100;
      3'd4: f = 4'b1101;
      3'd5: f = 4'b1010;
      3'd6: f = 4'b0110;
      default: f = 4'b1110;
    endcase
    return f;
  endfunction

  // fghj for control when the disparity after the 6-bit group is negative.
  function automatic logic [FOUR_W-1:0] four_neg_ctrl(input logic [Y_W-1:0] y);
    logic [FOUR_W-1:0] f;
    case (y)
      3'd0: f = 4'b1011;
      3'd1: f = 4'b0110;
      3'd2: f = 4'b1010;
      3'd3: f = 4'b1100;
      3'd4: f = 4'b1101;
      3'd5: f = 4'b0101;
      3'd6: f = 4'b1001;
      default: f = 4'b0111;
    endcase
    return f;
  endfunction

  function automatic logic ctrl_legal(input logic [BYTE_W-1:0] b);
    logic [X_W-1:0] x;
    logic           y7;
    x  = b[X_W-1:0];
    y7 = (b[BYTE_W-1:X_W] == 3'd7);
    return (x == 5'd28) ||
           (y7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  // The alternate y=7 form avoids a run of five equal bits across the group boundary.
  function automatic logic want_alt7(input logic [X_W-1:0] x, input logic rd);
    return rd ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
              : (x == 5'd17 || x == 5'd18 || x == 5'd20);
  endfunction

  function automatic logic rd_after(input logic rd_in, input int ones, input int half);
    if (ones > half)      return 1'b1;
    else if (ones < half) return 1'b0;
    else                  return rd_in;
  endfunction

endpackage

// File: rtl/tx8b10b_sub6.sv
module tx8b10b_sub6
  import tx8b10b_pkg::*;
(
  input  logic [X_W-1:0]   x_i,
  input  logic             k28_i,
  input  logic             rd_i,
  output logic [SIX_W-1:0] sym_o,
  output logic             rd_o
);
  logic [SIX_W-1:0] base;
  logic             unbal;
  logic             flip;

  always_comb begin
    base  = k28_i ? 6'b001111 : six_neg(x_i);
    unbal = ($countones(base) != SIX_W/2);
    flip  = rd_i && (unbal || (!k28_i && x_i == 5'd7));
    sym_o = flip ? ~base : base;
    rd_o  = rd_after(rd_i, $countones(sym_o), SIX_W/2);
  end
endmodule

// File: rtl/tx8b10b_sub4.sv
module tx8b10b_sub4
  import tx8b10b_pkg::*;
(
  input  logic [Y_W-1:0]    y_i,
  input  logic              ctrl_i,
  input  logic              alt_i,
  input  logic              rd_i,
  output logic [FOUR_W-1:0] sym_o,
  output logic              rd_o
);
  logic [FOUR_W-1:0] base;
  logic              flip;

  always_comb begin
    if (ctrl_i)     base = four_neg_ctrl(y_i);
    else if (alt_i) base = 4'b0111;
    else            base = four_neg_data(y_i);
    flip  = rd_i && (ctrl_i || ($countones(base) != FOUR_W/2) || (y_i == 3'd3));
    sym_o = flip ? ~base : base;
    rd_o  = rd_after(rd_i, $countones(sym_o), FOUR_W/2);
  end
endmodule

// File: rtl/tx8b10b_ctrl_check.sv
module tx8b10b_ctrl_check
  import tx8b10b_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctrl_i,
  output logic              k_ok_o,
  output logic              k_bad_o,
  output logic              k28_o
);
  logic legal;

  always_comb begin
    legal   = ctrl_legal(byte_i);
    k_ok_o  = ctrl_i && legal;
    k_bad_o = ctrl_i && !legal;
    k28_o   = k_ok_o && (byte_i[X_W-1:0] == 5'd28);
  end
endmodule

// File: rtl/tx_8b10b_encoder.sv
module tx_8b10b_encoder
  import tx8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_ctrl,
  input  logic              force_rd,
  input  logic              force_rd_val,
  output logic [SYM_W-1:0]  code_out,
  output logic              rd_out,
  output logic              ctrl_err
);
  logic [X_W-1:0]    x_val;
  logic [Y_W-1:0]    y_val;
  logic              rd_q;
  logic              rd_start;     // disparity the current character starts from
  logic              k_ok;
  logic              k_bad;
  logic              k28;
  logic [SIX_W-1:0]  sym6;
  logic              rd_mid;       // disparity between the two groups
  logic              alt7;
  logic [FOUR_W-1:0] sym4;
  logic              rd_next;
  logic [SYM_W-1:0]  enc_code;
  logic [SYM_W-1:0]  code_q;
  logic              err_q;

  assign x_val    = in_byte[X_W-1:0];
  assign y_val    = in_byte[BYTE_W-1:X_W];
  assign rd_start = force_rd ? force_rd_val : rd_q;

  tx8b10b_ctrl_check u_ctrl (
    .byte_i  (in_byte),
    .ctrl_i  (in_ctrl),
    .k_ok_o  (k_ok),
    .k_bad_o (k_bad),
    .k28_o   (k28)
  );

  tx8b10b_sub6 u_sub6 (
    .x_i   (x_val),
    .k28_i (k28),
    .rd_i  (rd_start),
    .sym_o (sym6),
    .rd_o  (rd_mid)
  );

  assign alt7 = !k_ok && (y_val == 3'd7) && want_alt7(x_val, rd_mid);

  tx8b10b_sub4 u_sub4 (
    .y_i    (y_val),
    .ctrl_i (k_ok),
    .alt_i  (alt7),
    .rd_i   (rd_mid),
    .sym_o  (sym4),
    .rd_o   (rd_next)
  );

  assign enc_code = {sym6, sym4};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      code_q <= '0;
      err_q  <= 1'b0;
    end else if (in_valid) begin
      rd_q   <= rd_next;
      code_q <= enc_code;
      err_q  <= k_bad;
    end
  end

  assign code_out = code_q;
  assign rd_out   = rd_q;
  assign ctrl_err = err_q;
endmodule

// File: rtl/tx_8b10b_encoder_chk.sv
module tx_8b10b_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ctrl,
  input logic       force_rd,
  input logic       force_rd_val,
  input logic [9:0] code_out,
  input logic       rd_out,
  input logic       ctrl_err,
  input logic       rd_start
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(code_out) && $stable(rd_out) && $stable(ctrl_err)));

  p_force_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && force_rd) |-> (rd_start == force_rd_val));

  p_weight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (($countones(code_out) >= 4) && ($countones(code_out) <= 6)));

  p_direction_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($past(rd_start) ? ($countones(code_out) <= 5)
                                  : ($countones(code_out) >= 5)));

  p_rd_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (($countones(code_out) == 5) ? (rd_out == $past(rd_start))
                                              : (rd_out == ($countones(code_out) == 6))));

  p_no_err_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ctrl) |=> !ctrl_err);

endmodule

bind tx_8b10b_encoder tx_8b10b_encoder_chk u_chk (.*);

// File: tb/tx_8b10b_encoder_tb.sv
`timescale 1ns/1ps
module tx_8b10b_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ctrl;
  logic       force_rd;
  logic       force_rd_val;
  logic [9:0] code_out;
  logic       rd_out;
  logic       ctrl_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tx_8b10b_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ctrl(in_ctrl), .force_rd(force_rd), .force_rd_val(force_rd_val),
    .code_out(code_out), .rd_out(rd_out), .ctrl_err(ctrl_err)
  );

  // Reference code tables, negative column.
  localparam logic [5:0] M6 [32] = '{
    6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
    6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
    6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
    6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
  localparam logic [3:0] M4D [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                                     4'b1101, 4'b1010, 4'b0110, 4'b1110};
  localparam logic [3:0] M4K [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                                     4'b1101, 4'b0101, 4'b1001, 4'b0111};
  localparam logic [7:0] KLIST [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                        8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};

  // Directed vectors: {ctrl, byte, forced start rd, expected code, expected end rd}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hBC, 1'b0, 10'b0011111010, 1'b1},
    {1'b1, 8'hBC, 1'b1, 10'b1100000101, 1'b0},
    {1'b0, 8'hB5, 1'b0, 10'b1010101010, 1'b0},
    {1'b0, 8'h00, 1'b0, 10'b1001110100, 1'b0},
    {1'b0, 8'hE7, 1'b0, 10'b1110001110, 1'b1},
    {1'b0, 8'hF1, 1'b0, 10'b1000110111, 1'b1},
    {1'b0, 8'hEB, 1'b1, 10'b1101001000, 1'b0},
    {1'b1, 8'hFC, 1'b0, 10'b0011111000, 1'b0},
    {1'b1, 8'hF7, 1'b1, 10'b0001010111, 1'b1},
    {1'b0, 8'h63, 1'b1, 10'b1100010011, 1'b1}};

  function automatic int ones(input logic [9:0] v);
    int n = 0;
    for (int i = 0; i < 10; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic bit legal_k(input logic [7:0] b);
    for (int i = 0; i < 12; i++) if (KLIST[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  // Returns {err, end rd, code}.
  function automatic logic [11:0] model(input logic k, input logic [7:0] b, input logic rd);
    logic [4:0] x;
    logic [2:0] y;
    logic       kok;
    logic [5:0] c6;
    logic [3:0] c4;
    logic       r;
    logic       alt;
    int         n6;
    int         n4;
    x   = b[4:0];
    y   = b[7:5];
    kok = k && legal_k(b);
    c6  = (kok && x == 5'd28) ? 6'b001111 : M6[x];
    n6  = ones({4'b0, c6});
    if (rd && (n6 != 3 || (x == 5'd7 && !(kok && x == 5'd28)))) c6 = ~c6;
    n6 = ones({4'b0, c6});
    r  = (n6 > 3) ? 1'b1 : (n6 < 3) ? 1'b0 : rd;
    if (kok) begin
      c4 = r ? ~M4K[y] : M4K[y];
    end else begin
      alt = (y == 3'd7) && ((!r && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                            ( r && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      c4  = alt ? 4'b0111 : M4D[y];
      if (r && (ones({6'b0, c4}) != 2 || y == 3'd3)) c4 = ~c4;
    end
    n4 = ones({6'b0, c4});
    r  = (n4 > 2) ? 1'b1 : (n4 < 2) ? 1'b0 : r;
    return {k && !kok, r, c6, c4};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got err/rd/code %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: apply inputs, wait one rising edge, return at next falling edge.
  task automatic send(input logic k, input logic [7:0] b, input logic fd, input logic fv);
    in_valid = 1'b1; in_ctrl = k; in_byte = b; force_rd = fd; force_rd_val = fv;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all reqs): got still running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp;
    logic        mrd;
    string       tag;
    int          run;
    logic        last;
    bit          first;
    bit          long_run;

    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_ctrl = 1'b0;
    force_rd = 1'b0; force_rd_val = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {ctrl_err, rd_out, code_out}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {ctrl_err, rd_out, code_out}, 12'h000);

    // R1: first character after reset from negative column.
    send(1'b1, 8'hBC, 1'b0, 1'b0);
    check("R1 first char K28.5", {ctrl_err, rd_out, code_out}, {1'b0, 1'b1, 10'b0011111010});

    // R10: one edge of latency.
    in_valid = 1'b1; in_ctrl = 1'b0; in_byte = 8'hB5; force_rd = 1'b0;
    #1;
    check("R10 no change before edge", {ctrl_err, rd_out, code_out}, {1'b0, 1'b1, 10'b0011111010});
    @(negedge clk);
    check("R10 value after one edge", {ctrl_err, rd_out, code_out}, {1'b0, 1'b1, 10'b1010101010});

    // R8: valid low holds everything, even with a forced start and an illegal control byte.
    in_valid = 1'b0; in_ctrl = 1'b1; in_byte = 8'h00; force_rd = 1'b1; force_rd_val = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold while idle", {ctrl_err, rd_out, code_out}, {1'b0, 1'b1, 10'b1010101010});

    // R2 R4 R6 R7: directed vectors with known codes.
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20], VEC[i][19:12], 1'b1, VEC[i][11]);
      check("R7 R2 R4 R6 directed vector", {ctrl_err, rd_out, code_out},
            {1'b0, VEC[i][0], VEC[i][10:1]});
    end

    // R7: forced start overrides tracked disparity (tracked now 1, force 0).
    send(1'b0, 8'h00, 1'b1, 1'b0);
    check("R7 force negative over positive", {ctrl_err, rd_out, code_out},
          {1'b0, 1'b0, 10'b1001110100});

    // R5: illegal control byte.
    send(1'b1, 8'h00, 1'b1, 1'b0);
    check("R5 illegal K", {ctrl_err, rd_out, code_out}, {1'b1, 1'b0, 10'b1001110100});

    // Full sweep from both forced starts.
    for (int rdv = 0; rdv < 2; rdv++) begin
      for (int kv = 0; kv < 2; kv++) begin
        for (int bv = 0; bv < 256; bv++) begin
          exp = model(kv[0], bv[7:0], rdv[0]);
          send(kv[0], bv[7:0], 1'b1, rdv[0]);
          if (kv != 0 && legal_k(bv[7:0]))           tag = "R4 sweep control";
          else if (kv != 0)                          tag = "R5 sweep illegal control";
          else if (bv[7:5] == 3'd7)                  tag = "R6 sweep D.x.7";
          else                                       tag = "R2 sweep data";
          check(tag, {ctrl_err, rd_out, code_out}, exp);
          n_tests++;
          if (ones(code_out) < 4 || ones(code_out) > 6 ||
              (rdv == 0 && ones(code_out) == 4) || (rdv == 1 && ones(code_out) == 6)) begin
            n_fail++;
            $display("FAIL R11 weight: got %0d ones from start %0d, expected balanced form",
                     ones(code_out), rdv);
          end
        end
      end
    end

    // R3 R9: unforced stream from a fresh reset.
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {ctrl_err, rd_out, code_out}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    mrd = 1'b0; first = 1'b1; run = 0; last = 1'b0;
    for (int i = 0; i < 600; i++) begin
      logic       kk;
      logic [7:0] bb;
      kk = (i % 5 == 4);
      bb = kk ? KLIST[i % 12] : 8'((i * 37) % 256);
      exp = model(kk, bb, mrd);
      send(kk, bb, 1'b0, 1'b0);
      check("R3 stream tracking", {ctrl_err, rd_out, code_out}, exp);
      mrd = exp[10];
      long_run = 1'b0;
      for (int j = 9; j >= 0; j--) begin
        if (!first && code_out[j] == last) run++;
        else begin run = 1; last = code_out[j]; end
        first = 1'b0;
        if (run > 5) long_run = 1'b1;
      end
      n_tests++;
      if (long_run) begin
        n_fail++;
        $display("FAIL R9 run length: got run above 5 at char %0d, expected at most 5", i);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule